// File: doc/BRIEF.md
# Grouped Secondary Interrupt Controller

This block collects 32 peripheral interrupt sources and reduces them to three group request lines for a primary interrupt controller. Sources 0 to 7 make up the audio group. Sources 8 to 15 make up the miscellaneous group, which covers the real-time clock, keyboard, mouse and three count/compare timers. Sources 16 to 31 make up the super-I/O group: four parallel-port sources and two six-source serial channels. Each group line is high while any enabled source in that group is pending. A handler can then read which enabled source has the lowest number and service that one first.

Most sources are level-type, and their status bit follows the live input. Three sources (16, 22 and 28) are edge-type. A rising edge on one of them sets a sticky status bit, and software clears that bit by writing 0 to it. Two word-addressed registers sit on a simple write-strobe bus with a combinational read port: an enable mask and the status view.

Top module: `grp_irq_ctrl`

## Requirements
- R1: After reset the mask register reads 0 and every edge-type status bit reads 0, so all group outputs and the service-valid output are low.
- R2: A bus write to word address 0 loads the mask register in full. Reading address 0 returns the current mask.
- R3: Reading word address 1 returns the status. For level-type bits this is the live source input, combinationally.
- R4: Source bits 16, 22 and 28 are edge-type. A 0-to-1 transition on one of them sets its status bit at the next clock edge. The bit then stays set after the source returns low.
- R5: Writing status (address 1) with 0 in an edge-type bit position clears that bit. Writing 1 in that position leaves it unchanged. A source that is still held high after a clear does not set the bit again until it makes a new 0-to-1 transition.
- R6: Status writes have no effect on level-type bit positions. Their status keeps following the source input.
- R7: When a new edge arrives in the same cycle as a clearing write to that bit, the edge wins and the bit ends up set.
- R8: The three group outputs are the OR of (status AND mask) over their ranges. grp_irq_o[0] covers bits 0-7, grp_irq_o[1] covers bits 8-15, and grp_irq_o[2] covers bits 16-31.
- R9: svc_valid_o is high when any enabled source is pending. svc_idx_o then gives the lowest-numbered pending enabled source. When svc_valid_o is low, svc_idx_o is 0.
- R10: A pending source whose mask bit is 0 affects neither the group outputs nor the service index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Peripheral interrupt sources, active high |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Word address (0 = mask, 1 = status) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| grp_irq_o | output | 3 | Group requests: [0] audio, [1] miscellaneous, [2] super-I/O |
| svc_valid_o | output | 1 | Some enabled source is pending |
| svc_idx_o | output | 5 | Lowest pending enabled source number |

## Verification
Several properties are checked by assertions on every cycle:
- an edge-type bit holds while no write clears it;
- a fresh edge always leaves its bit set, even against a clear;
- a clear with no edge drops the bit;
- a mask write lands in full;
- the reported index is pending, enabled and has no lower enabled pending source.

Other behaviour can only be shown by the bench's scenarios. These are the actual group ranges, the combinational status readback of level bits, that a held-high edge source does not set its bit again after a clear, and that writes to level positions change nothing visible.

// File: rtl/grp_irq_pkg.sv
package grp_irq_pkg;
  localparam int NSRC    = 32;
  localparam int IDX_W   = $clog2(NSRC);
  localparam int N_GRP   = 3;
  localparam int ADDR_W  = 2;
  localparam logic [ADDR_W-1:0] MASK_ADDR = 2'd0;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 2'd1;
  // edge-latched source positions: 16, 22, 28
  localparam logic [NSRC-1:0] EDGE_BITS = (NSRC'(1) << 16) | (NSRC'(1) << 22) | (NSRC'(1) << 28);

  // bit selection for group g: audio 0-7, misc 8-15, super-I/O 16-31
  function automatic logic [NSRC-1:0] grp_sel(input int g);
    logic [NSRC-1:0] s;
    s = '0;
    for (int i = 0; i < NSRC; i++) begin
      case (g)
        0:       s[i] = (i < 8);
        1:       s[i] = (i >= 8) && (i < 16);
        default: s[i] = (i >= 16);
      endcase
    end
    return s;
  endfunction

  // lowest set bit index, 0 when empty
  function automatic logic [IDX_W-1:0] lowest_set(input logic [NSRC-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NSRC-1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/grp_irq_mask.sv
module grp_irq_mask
  import grp_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mask_wr,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] mask_o
);
  logic [NSRC-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= wdata;
  end

  assign mask_o = mask_q;

  p_mask_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_o == $past(wdata)));
endmodule

// File: rtl/grp_irq_status.sv
module grp_irq_status
  import grp_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic            stat_wr,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] stat_o,
  output logic [NSRC-1:0] rise_o
);
  logic [NSRC-1:0] src_q;
  logic [NSRC-1:0] edge_q;
  logic [NSRC-1:0] clr_vec;

  assign rise_o  = src & ~src_q & EDGE_BITS;
  assign clr_vec = stat_wr ? ~wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      edge_q <= '0;
    end else begin
      src_q  <= src;
      edge_q <= EDGE_BITS & (rise_o | (edge_q & ~clr_vec));
    end
  end

  assign stat_o = (edge_q & EDGE_BITS) | (src & ~EDGE_BITS);

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    if (EDGE_BITS[i]) begin : g_edge
      p_edge_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o[i] && !(stat_wr && !wdata[i])) |=> stat_o[i]);
      p_edge_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o[i] |=> stat_o[i]);
      p_edge_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !wdata[i] && !rise_o[i]) |=> !stat_o[i]);
    end
  end
endmodule

// File: rtl/grp_irq_select.sv
module grp_irq_select
  import grp_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  pend,
  output logic [N_GRP-1:0] grp_o,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    localparam logic [NSRC-1:0] SEL = grp_sel(g);
    assign grp_o[g] = |(pend & SEL);
  end

  assign valid_o = |pend;
  assign idx_o   = valid_o ? lowest_set(pend) : '0;

  p_valid_groups_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o == (|grp_o));
  p_idx_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> pend[idx_o]);
  p_idx_lowest_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ((pend & ~({NSRC{1'b1}} << idx_o)) == '0));
  p_idx_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (idx_o == '0));
endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl
  import grp_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       src_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic [2:0]        grp_irq_o,
  output logic              svc_valid_o,
  output logic [4:0]        svc_idx_o
);
  logic            mask_wr;
  logic            stat_wr;
  logic [NSRC-1:0] mask;
  logic [NSRC-1:0] stat;
  logic [NSRC-1:0] rise;
  logic [NSRC-1:0] pend;

  assign mask_wr = reg_we_i && (reg_addr_i == MASK_ADDR);
  assign stat_wr = reg_we_i && (reg_addr_i == STAT_ADDR);

  grp_irq_mask u_mask (
    .clk(clk), .rst_n(rst_n), .mask_wr(mask_wr), .wdata(reg_wdata_i), .mask_o(mask)
  );

  grp_irq_status u_stat (
    .clk(clk), .rst_n(rst_n), .src(src_i), .stat_wr(stat_wr),
    .wdata(reg_wdata_i), .stat_o(stat), .rise_o(rise)
  );

  assign pend = stat & mask;

  grp_irq_select u_sel (
    .clk(clk), .rst_n(rst_n), .pend(pend),
    .grp_o(grp_irq_o), .valid_o(svc_valid_o), .idx_o(svc_idx_o)
  );

  always_comb begin
    case (reg_addr_i)
      MASK_ADDR: reg_rdata_o = mask;
      STAT_ADDR: reg_rdata_o = stat;
      default:   reg_rdata_o = '0;
    endcase
  end

  // masked sources never reach the summary outputs
  p_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> (grp_irq_o == '0 && !svc_valid_o));
  p_rise_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((stat & $past(rise)) == $past(rise)));
endmodule

// File: tb/sim_grp_irq_ctrl.sv
`timescale 1ns/1ps
module sim_grp_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  grp;
  logic        valid;
  logic [4:0]  idx;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  grp_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .grp_irq_o(grp),
    .svc_valid_o(valid), .svc_idx_o(idx)
  );

  // {mask, src, grp, valid, idx}; level-type sources only
  localparam logic [72:0] VEC [8] = '{
    {32'hFFFF_FFFF, 32'h0000_0000, 3'b000, 1'b0, 5'd0},
    {32'hFFFF_FFFF, 32'h0000_0080, 3'b001, 1'b1, 5'd7},
    {32'hFFFF_FFFF, 32'h0000_0300, 3'b010, 1'b1, 5'd8},
    {32'hFFFF_FFFF, 32'h0002_0000, 3'b100, 1'b1, 5'd17},
    {32'h0000_FF00, 32'h0002_0081, 3'b000, 1'b0, 5'd0},
    {32'hFFFF_00FF, 32'h8000_8004, 3'b101, 1'b1, 5'd2},
    {32'hFFFF_FFFE, 32'h0000_0003, 3'b001, 1'b1, 5'd1},
    {32'h8000_0000, 32'h8000_0001, 3'b100, 1'b1, 5'd31}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input string req, input logic [31:0] exp);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic outs(input string req, input logic [2:0] eg, input logic ev, input logic [4:0] ei);
    #1;
    check({req, " grp"}, {29'd0, grp}, {29'd0, eg});
    check({req, " valid"}, {31'd0, valid}, {31'd0, ev});
    check({req, " idx"}, {27'd0, idx}, {27'd0, ei});
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, "R1 mask", 32'h0);
    rd(2'd1, "R1 status", 32'h0);
    outs("R1", 3'b000, 1'b0, 5'd0);

    // R2 mask readback
    wr(2'd0, 32'hA5A5_5A5A);
    rd(2'd0, "R2 mask", 32'hA5A5_5A5A);

    // R3 level status is live
    src = 32'h0000_1234;
    rd(2'd1, "R3 status", 32'h0000_1234);
    src = '0;

    // R8 R9 R10 table walk
    for (int k = 0; k < 8; k++) begin
      wr(2'd0, VEC[k][72:41]);
      src = VEC[k][40:9];
      outs($sformatf("R8/R9/R10 vec%0d", k), VEC[k][8:6], VEC[k][5], VEC[k][4:0]);
    end
    src = '0;

    // R4 edge bit 16 latches on a one-cycle pulse
    wr(2'd0, 32'hFFFF_FFFF);
    @(negedge clk); src = 32'h0001_0000;
    @(negedge clk); src = '0;
    @(negedge clk);
    rd(2'd1, "R4 latched", 32'h0001_0000);
    outs("R4", 3'b100, 1'b1, 5'd16);

    // R5 writing 1 keeps, writing 0 clears
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, "R5 keep", 32'h0001_0000);
    wr(2'd1, 32'hFFFE_FFFF);
    rd(2'd1, "R5 clear", 32'h0);

    // R7 edge coincident with clear wins
    @(negedge clk);
    src = 32'h0040_0000; we = 1'b1; addr = 2'd1; wdata = 32'h0;
    @(negedge clk);
    we = 1'b0; src = '0;
    rd(2'd1, "R7 edge wins", 32'h0040_0000);

    // R6 status write ignored at level positions
    src = 32'h0000_0F00;
    wr(2'd1, 32'hFFBF_F0FF);
    rd(2'd1, "R6 level kept, bit22 cleared", 32'h0000_0F00);
    outs("R6", 3'b010, 1'b1, 5'd8);
    src = '0;

    // R5 held-high edge source does not relatch after clear
    @(negedge clk); src = 32'h1000_0000;
    @(negedge clk);
    rd(2'd1, "R4 bit28 set", 32'h1000_0000);
    wr(2'd1, 32'h0);
    @(negedge clk);
    rd(2'd1, "R5 held source no relatch", 32'h0);
    outs("R5 held", 3'b000, 1'b0, 5'd0);
    src = '0;

    // R1 reset mid-run clears mask and latches
    @(negedge clk); src = 32'h0001_0000;
    @(negedge clk); src = '0;
    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(2'd0, "R1 re-reset mask", 32'h0);
    rd(2'd1, "R1 re-reset status", 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule